// File: doc/BRIEF.md
# Watchdog and Interval Timer with Keyed Register Writes

This block is an up-counting timer that serves either as a watchdog or as a periodic interval timer. A free-running prescaler, driven by the peripheral clock, offers eight divide taps. A 3-bit select picks one tap, and each pulse from that tap advances the counter by one. When the counter wraps from all ones to zero, the active mode decides the result. Watchdog mode raises a one-cycle internal reset request. Interval mode raises an interrupt that stays high until software acknowledges it.

Software uses a small register port with two addresses: 0 for the control/status byte and 1 for the counter. A write counts only when it is a 16-bit access whose upper byte matches the key for that address. The lower byte then carries the new value. Reads are byte-wide and return their data one cycle after the request.

The control/status byte keeps its value through the internal reset that the chip applies after a watchdog overflow. Only the external power-on reset clears it.

Top module: `wdt_ivl_timer`

## Requirements
- R1: After the power-on reset (`por_n` low), the control/status byte and the counter read 0, and `irq` and `rst_req` are low.
- R2: A write to address 0 is accepted only when `wr_wide`=1 and `wr_data[15:8]`=0xA5. A write to address 1 is accepted only when `wr_wide`=1 and `wr_data[15:8]`=0x5A. Any other write changes nothing.
- R3: A read with `rd_en`=1 returns its data on `rd_data` with `rd_valid` high in the next cycle. Address 1 returns the counter. Address 0 returns the control/status byte, laid out as follows:
  - bit 7: enable
  - bit 6: mode (1 = watchdog, 0 = interval)
  - bit 5: reset-kind select
  - bit 4: watchdog overflow flag
  - bit 3: interval overflow flag
  - bits 2:0: clock select
- R4: While the enable bit is 0, the counter holds its value.
- R5: Clock select values 0 to 7 divide by 1, 2, 4, 8, 16, 64, 256 and 4096. From the edge that sets the enable bit, the counter advances once every N enabled edges, where N is the selected divide.
- R6: In interval mode, a wrap from 0xFF to 0x00 sets the interval flag. `irq` follows that flag, and `rst_req` stays low.
- R7: In watchdog mode, a wrap sets the watchdog flag and raises `rst_req` for exactly one cycle. During that cycle, `rst_kind` shows bit 5.
- R8: A flag clears only when an accepted write carries 0 for it and the previous accepted control write was followed by a read of that flag as 1. Writing 1 to a flag, or writing 0 to it without such a read, leaves the flag unchanged.
- R9: `chip_rst` clears the counter and the prescaler, and leaves the control/status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Asynchronous external power-on reset, active low |
| chip_rst | input | 1 | Synchronous internal chip reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write address: 0 = control/status, 1 = counter |
| wr_wide | input | 1 | 1 marks a 16-bit access |
| wr_data | input | 16 | Key in the upper byte, value in the lower byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 1 | Interval overflow interrupt |
| rst_req | output | 1 | One-cycle internal reset request |
| rst_kind | output | 1 | Reset-kind select that goes with rst_req |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, the 0xA5 and 0x5A keys, and a 12-bit prescaler. With these values the slowest tap, divide by 4096, is reached in a few thousand cycles, so every divide setting can be run, not just the fast ones. Presetting the counter to 0xFE through the keyed counter write puts overflow in both modes two edges away. This makes it possible to check the exact cycle of the reset pulse and of the interrupt, and then the read-then-write-zero acknowledge sequence.

// File: rtl/wdt_ivl_timer.sv
module wdt_ivl_timer #(
  parameter int DATA_W = 8,
  parameter logic [7:0] CSR_KEY = 8'hA5,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter int PRE_W = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              chip_rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic              wr_wide,
  input  logic [2*DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq,
  output logic              rst_req,
  output logic              rst_kind
);

  logic [7:0]        csr;
  logic [DATA_W-1:0] cnt;
  logic [PRE_W-1:0]  pre;
  logic              seen_w, seen_i;

  function automatic int tap_shift(input logic [2:0] sel);
    case (sel)
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      3'd5: return 6;
      3'd6: return 8;
      default: return 12;
    endcase
  endfunction

  wire              tme      = csr[7];
  wire              wdm      = csr[6];
  wire [DATA_W-1:0] key      = wr_data[2*DATA_W-1:DATA_W];
  wire              csr_wr   = wr_en && !wr_addr && wr_wide && key == CSR_KEY;
  wire              cnt_wr   = wr_en &&  wr_addr && wr_wide && key == CNT_KEY;
  wire [PRE_W-1:0]  tap_mask = PRE_W'((1 << tap_shift(csr[2:0])) - 1);
  wire              tick     = tme && ((pre & tap_mask) == tap_mask);
  wire              ovf      = tick && (cnt == '1) && !cnt_wr && !chip_rst;

  assign irq      = csr[3];
  assign rst_kind = csr[5];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      csr <= '0;
    end else if (csr_wr) begin
      csr[7:5] <= wr_data[7:5];
      csr[2:0] <= wr_data[2:0];
      csr[4]   <= (csr[4] && !(seen_w && !wr_data[4])) || (ovf && wdm);
      csr[3]   <= (csr[3] && !(seen_i && !wr_data[3])) || (ovf && !wdm);
    end else begin
      if (ovf && wdm)  csr[4] <= 1'b1;
      if (ovf && !wdm) csr[3] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seen_w <= 1'b0;
      seen_i <= 1'b0;
    end else if (csr_wr || chip_rst) begin
      seen_w <= 1'b0;
      seen_i <= 1'b0;
    end else if (rd_en && !rd_addr) begin
      seen_w <= seen_w || csr[4];
      seen_i <= seen_i || csr[3];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (chip_rst)   cnt <= '0;
    else if (cnt_wr)     cnt <= wr_data[DATA_W-1:0];
    else if (tick)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                pre <= '0;
    else if (chip_rst || !tme) pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_req  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rst_req  <= ovf && wdm;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_addr ? cnt : csr;
    end
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req) else $error("reset request longer than one cycle"); // R7
  AST_WD_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    (ovf && wdm) |=> (rst_req && csr[4] && cnt == '0)) else $error("watchdog overflow"); // R7
  AST_IV_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    (ovf && !wdm) |=> (irq && !rst_req)) else $error("interval overflow"); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!por_n)
    (!tme && !cnt_wr && !chip_rst) |=> $stable(cnt)) else $error("count while disabled"); // R4
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (!csr_wr) |=> (csr[7:5] == $past(csr[7:5]) && csr[2:0] == $past(csr[2:0])))
    else $error("control changed without keyed write"); // R2
  AST_CHIP_RST_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    (chip_rst && !csr_wr) |=> ($stable(csr) && cnt == '0)) else $error("chip reset"); // R9

endmodule

// File: tb/wdt_ivl_timer_bench.sv
module wdt_ivl_timer_bench;
  logic clk = 1'b0, por_n = 1'b0, chip_rst = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_valid, irq, rst_req, rst_kind;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  wdt_ivl_timer u_wdt_ivl_timer (
    .clk(clk), .por_n(por_n), .chip_rst(chip_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq), .rst_req(rst_req), .rst_kind(rst_kind));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", 8'h1, 8'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(logic a, logic wide, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_wide = wide; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic div_run(logic [2:0] sel, int k, logic [7:0] exp, string tag);
    wr(1'b1, 1'b1, 16'h5A00);
    wr(1'b0, 1'b1, {8'hA5, 5'b10000, sel});
    repeat (k) @(negedge clk);
    wr(1'b0, 1'b1, {8'hA5, 5'b00000, sel});
    rd(1'b1, exp, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {7'b0, irq}, 8'h0);
    chk("R1 rst_req", {7'b0, rst_req}, 8'h0);
    rd(1'b0, 8'h00, "R1 csr");
    rd(1'b1, 8'h00, "R1 cnt");

    div_run(3'd0, 4, 8'd5, "R5 div1");
    div_run(3'd3, 19, 8'd2, "R5 div8");
    div_run(3'd5, 127, 8'd2, "R5 div64");
    div_run(3'd7, 4095, 8'd1, "R5 div4096");
    repeat (10) @(negedge clk);
    rd(1'b1, 8'd1, "R4 hold");

    wr(1'b1, 1'b1, 16'h5AFE);
    wr(1'b0, 1'b1, 16'hA580);
    @(negedge clk);
    chk("R6 irq before wrap", {7'b0, irq}, 8'h0);
    @(negedge clk);
    chk("R6 irq at wrap", {7'b0, irq}, 8'h1);
    chk("R6 no rst_req", {7'b0, rst_req}, 8'h0);
    wr(1'b0, 1'b1, 16'hA500);
    rd(1'b0, 8'h08, "R6 csr flag");
    rd(1'b1, 8'h01, "R6 cnt after wrap");
    wr(1'b0, 1'b1, 16'hA508);
    wr(1'b0, 1'b1, 16'hA500);
    rd(1'b0, 8'h08, "R8 flag kept without read");
    wr(1'b0, 1'b1, 16'hA500);
    chk("R8 irq cleared", {7'b0, irq}, 8'h0);
    rd(1'b0, 8'h00, "R8 csr cleared");

    wr(1'b1, 1'b1, 16'h5AFE);
    wr(1'b0, 1'b1, 16'hA5E0);
    @(negedge clk);
    chk("R7 rst_req before wrap", {7'b0, rst_req}, 8'h0);
    @(negedge clk);
    chk("R7 rst_req at wrap", {7'b0, rst_req}, 8'h1);
    chk("R7 rst_kind", {7'b0, rst_kind}, 8'h1);
    @(negedge clk);
    chk("R7 rst_req one cycle", {7'b0, rst_req}, 8'h0);
    wr(1'b0, 1'b1, 16'hA560);
    rd(1'b0, 8'h70, "R7 csr flag");
    chk("R7 no irq", {7'b0, irq}, 8'h0);

    wr(1'b1, 1'b1, 16'h5A33);
    chip_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chip_rst = 1'b0;
    rd(1'b1, 8'h00, "R9 cnt cleared");
    rd(1'b0, 8'h70, "R9 csr kept");

    wr(1'b0, 1'b0, 16'hA580);
    wr(1'b0, 1'b1, 16'h5A80);
    wr(1'b1, 1'b1, 16'hA577);
    wr(1'b1, 1'b0, 16'h5A77);
    rd(1'b0, 8'h70, "R2 csr unchanged");
    rd(1'b1, 8'h00, "R2 cnt unchanged");
    wr(1'b1, 1'b1, 16'h5A44);
    rd(1'b1, 8'h44, "R2 keyed cnt write");

    @(negedge clk);
    chk("R3 read queue drained", 8'(exp_q.size()), 8'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule